// File: doc/BRIEF.md
# Store Instruction Completion Tracker

This block follows store instructions whose lanes turn into several line-sized write requests toward memory. It holds a small table keyed by instruction sequence number. Every write request issued for an instruction raises that instruction's outstanding count. Every acknowledgement coming back from the memory side lowers it. A separate strobe reports that the instruction has no lane requests left waiting to be coalesced.

Only when both conditions hold, so that nothing is outstanding and nothing remains to be issued, does the block send one completion toward the requester. That completion carries the sequence number and the requester port recorded with the instruction's first write request. The table entry is then released.

Requests for a new instruction are held off when the table is full. They are also held off when an instruction's count is at its ceiling. Acknowledgements that name nothing tracked are reported as errors.

Top module: `wct_tracker`

## Requirements
- R1: The first accepted write request for a sequence number claims the lowest-numbered free entry with an outstanding count of 1. Each later accepted request for that sequence number adds 1.
- R2: An acknowledgement for a tracked sequence number whose count is nonzero lowers that count by 1.
- R3: A completion (`cmp_valid` high for one cycle, one clock after the deciding input) is produced only when the entry's count is zero and its all-issued flag, set by `issued_valid`, is present. The two conditions may be met in either order.
- R4: Each tracked instruction yields exactly one completion, and its entry is freed in the same clock. A later acknowledgement for that sequence number is an error.
- R5: An acknowledgement whose sequence number is not tracked, or whose entry count is zero with no same-cycle request, raises `ack_err` for one cycle on the next clock and changes no entry.
- R6: `cmp_port` returns the `req_port` value of the instruction's first request. Port values on later requests are ignored.
- R7: A request and an acknowledgement for the same tracked sequence number in the same cycle leave its count unchanged.
- R8: `req_ready` is low when the requested sequence number is untracked and all entries are in use. It is also low when the matching entry's count equals 2^CNT_W-1. Otherwise it is high.
- R9: When several entries become complete together, the lowest-numbered entry completes first and the rest follow on later cycles, one per cycle.
- R10: `issued_valid` for a sequence number that has no entry is ignored.
- R11: After reset no entry is in use, `cmp_valid` and `ack_err` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A line write request is being issued for an instruction |
| req_seq | input | SEQ_W | Sequence number of the requesting instruction |
| req_port | input | PORT_W | Requester port to answer on completion |
| req_ready | output | 1 | Request can be accepted this cycle |
| ack_valid | input | 1 | Write-complete acknowledgement from memory |
| ack_seq | input | SEQ_W | Sequence number the acknowledgement names |
| ack_err | output | 1 | Acknowledgement matched no usable entry |
| issued_valid | input | 1 | Instruction has no more lane requests to issue |
| issued_seq | input | SEQ_W | Sequence number that finished issuing |
| cmp_valid | output | 1 | One-cycle completion pulse |
| cmp_seq | output | SEQ_W | Completed instruction's sequence number |
| cmp_port | output | PORT_W | Requester port captured at the first request |

## Verification
The completion rule is driven in both orders: acknowledgements draining before the all-issued strobe, and the strobe arriving before the last acknowledgement. This separates a design that waits on both conditions from one that watches only the count. Same-cycle request-plus-acknowledgement traffic tells a netting counter apart from one that drops either event. Filling the table, then saturating one count, shows that stalls come only from those two causes. Two entries finishing in one clock reveal the ordering between them, and a strobe for an untracked number followed by a real request shows it left no stale flag behind.

// File: rtl/wct_pkg.sv
package wct_pkg;
    localparam int DFLT_ENTRIES = 4;
    localparam int DFLT_SEQ_W   = 8;
    localparam int DFLT_PORT_W  = 4;
    localparam int DFLT_CNT_W   = 4;

    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_UP   = 2'd1,
        CNT_DOWN = 2'd2
    } cnt_step_e;
endpackage

// File: rtl/wct_match.sv
module wct_match #(
    parameter int N_ENT = 4,
    parameter int SEQ_W = 8
) (
    input  logic [N_ENT-1:0]       vld,
    input  logic [N_ENT*SEQ_W-1:0] seqs,
    input  logic [SEQ_W-1:0]       key,
    output logic [N_ENT-1:0]       hit
);
    for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
        assign hit[i] = vld[i] && (seqs[i*SEQ_W +: SEQ_W] == key);
    end
endmodule

// File: rtl/wct_pick.sv
module wct_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] oh
);
    logic [N-1:0] seen;

    assign seen[0] = 1'b0;
    for (genvar i = 1; i < N; i++) begin : g_seen
        assign seen[i] = seen[i-1] | req[i-1];
    end
    for (genvar i = 0; i < N; i++) begin : g_oh
        assign oh[i] = req[i] & ~seen[i];
    end
endmodule

// File: rtl/wct_tracker.sv
module wct_tracker
    import wct_pkg::*;
#(
    parameter int N_ENT  = DFLT_ENTRIES,
    parameter int SEQ_W  = DFLT_SEQ_W,
    parameter int PORT_W = DFLT_PORT_W,
    parameter int CNT_W  = DFLT_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [SEQ_W-1:0]  req_seq,
    input  logic [PORT_W-1:0] req_port,
    output logic              req_ready,
    input  logic              ack_valid,
    input  logic [SEQ_W-1:0]  ack_seq,
    output logic              ack_err,
    input  logic              issued_valid,
    input  logic [SEQ_W-1:0]  issued_seq,
    output logic              cmp_valid,
    output logic [SEQ_W-1:0]  cmp_seq,
    output logic [PORT_W-1:0] cmp_port
);
    localparam int SEQS_W = N_ENT * SEQ_W;

    typedef struct packed {
        logic              vld;
        logic [SEQ_W-1:0]  seq;
        logic [PORT_W-1:0] port;
        logic [CNT_W-1:0]  cnt;
        logic              issued;
    } entry_t;

    typedef struct packed {
        logic              cmp_v;
        logic [SEQ_W-1:0]  cmp_seq;
        logic [PORT_W-1:0] cmp_port;
        logic              err;
    } out_t;

    entry_t [N_ENT-1:0] ent_q, ent_d, ent_mid;
    out_t               out_q, out_d;

    logic [N_ENT-1:0]  vld_vec, free_vec, sat_vec, rdy_vec;
    logic [N_ENT-1:0]  req_hit, ack_hit, cmp_hit, alloc_oh, pick_oh;
    logic [SEQS_W-1:0] seq_flat;
    logic              req_any, req_sat, req_fire, ack_ok;

    for (genvar i = 0; i < N_ENT; i++) begin : g_flat
        assign vld_vec[i]                    = ent_q[i].vld;
        assign free_vec[i]                   = ~ent_q[i].vld;
        assign sat_vec[i]                    = &ent_q[i].cnt;
        assign seq_flat[i*SEQ_W +: SEQ_W]    = ent_q[i].seq;
    end

    wct_match #(.N_ENT(N_ENT), .SEQ_W(SEQ_W)) u_req_match (
        .vld(vld_vec), .seqs(seq_flat), .key(req_seq), .hit(req_hit)
    );
    wct_match #(.N_ENT(N_ENT), .SEQ_W(SEQ_W)) u_ack_match (
        .vld(vld_vec), .seqs(seq_flat), .key(ack_seq), .hit(ack_hit)
    );
    wct_match #(.N_ENT(N_ENT), .SEQ_W(SEQ_W)) u_cmp_match (
        .vld(vld_vec), .seqs(seq_flat), .key(out_q.cmp_seq), .hit(cmp_hit)
    );

    wct_pick #(.N(N_ENT)) u_alloc_pick (.req(free_vec), .oh(alloc_oh));
    wct_pick #(.N(N_ENT)) u_done_pick  (.req(rdy_vec),  .oh(pick_oh));

    assign req_any   = |req_hit;
    assign req_sat   = |(req_hit & sat_vec);
    assign req_ready = req_any ? !req_sat : |free_vec;
    assign req_fire  = req_valid && req_ready;

    // Stage 1: count updates, allocation and issued flags.
    always_comb begin
        ent_mid = ent_q;
        ack_ok  = 1'b0;
        rdy_vec = '0;
        for (int i = 0; i < N_ENT; i++) begin
            logic      inc;
            logic      dec;
            cnt_step_e step;
            inc  = req_fire && req_hit[i];
            dec  = ack_valid && ack_hit[i] && ((ent_q[i].cnt != '0) || inc);
            step = CNT_HOLD;
            if (dec) ack_ok = 1'b1;
            if (inc && !dec)      step = CNT_UP;
            else if (dec && !inc) step = CNT_DOWN;
            case (step)
                CNT_UP:   ent_mid[i].cnt = ent_q[i].cnt + CNT_W'(1);
                CNT_DOWN: ent_mid[i].cnt = ent_q[i].cnt - CNT_W'(1);
                default:  ent_mid[i].cnt = ent_q[i].cnt;
            endcase
            if (req_fire && !req_any && alloc_oh[i]) begin
                ent_mid[i].vld    = 1'b1;
                ent_mid[i].seq    = req_seq;
                ent_mid[i].port   = req_port;
                ent_mid[i].cnt    = CNT_W'(1);
                ent_mid[i].issued = 1'b0;
            end
            if (issued_valid && ent_mid[i].vld && (ent_mid[i].seq == issued_seq))
                ent_mid[i].issued = 1'b1;
            rdy_vec[i] = ent_mid[i].vld && (ent_mid[i].cnt == '0) && ent_mid[i].issued;
        end
    end

    // Stage 2: retire one complete entry and form the outputs.
    always_comb begin
        ent_d     = ent_mid;
        out_d     = '0;
        out_d.err = ack_valid && !ack_ok;
        for (int i = 0; i < N_ENT; i++) begin
            if (pick_oh[i]) begin
                out_d.cmp_v    = 1'b1;
                out_d.cmp_seq  = ent_mid[i].seq;
                out_d.cmp_port = ent_mid[i].port;
                ent_d[i]       = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q <= '0;
            out_q <= '0;
        end else begin
            ent_q <= ent_d;
            out_q <= out_d;
        end
    end

    assign cmp_valid = out_q.cmp_v;
    assign cmp_seq   = out_q.cmp_seq;
    assign cmp_port  = out_q.cmp_port;
    assign ack_err   = out_q.err;

    // R4: the entry is gone by the time its completion is visible.
    a_r4_freed_on_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |-> (cmp_hit == '0));

    // R4: two completions in a row never repeat an instruction.
    a_r4_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && $past(cmp_valid)) |-> (cmp_seq != $past(cmp_seq)));

    // R5: an error pulse always follows an acknowledgement.
    a_r5_err_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ack_err |-> $past(ack_valid));

    // R1: a sequence number never occupies two entries.
    a_r1_unique_req: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_hit));

    // R2: acknowledgements match at most one entry.
    a_r2_unique_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_hit));
endmodule

// File: tb/wct_tracker_tb.sv
module wct_tracker_tb;
    localparam int SEQ_W  = 8;
    localparam int PORT_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [SEQ_W-1:0]  req_seq = '0;
    logic [PORT_W-1:0] req_port = '0;
    logic              req_ready;
    logic              ack_valid = 1'b0;
    logic [SEQ_W-1:0]  ack_seq = '0;
    logic              ack_err;
    logic              issued_valid = 1'b0;
    logic [SEQ_W-1:0]  issued_seq = '0;
    logic              cmp_valid;
    logic [SEQ_W-1:0]  cmp_seq;
    logic [PORT_W-1:0] cmp_port;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    wct_tracker u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_seq(req_seq), .req_port(req_port), .req_ready(req_ready),
        .ack_valid(ack_valid), .ack_seq(ack_seq), .ack_err(ack_err),
        .issued_valid(issued_valid), .issued_seq(issued_seq),
        .cmp_valid(cmp_valid), .cmp_seq(cmp_seq), .cmp_port(cmp_port)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_cmp(input string tag, input bit v, input int s, input int p);
        chk({tag, " cmp_valid"}, cmp_valid, v);
        if (v) begin
            chk({tag, " cmp_seq"}, cmp_seq, s);
            chk({tag, " cmp_port"}, cmp_port, p);
        end
    endtask

    // One cycle of stimulus; outputs are valid on return.
    task automatic step(input bit rv, input int rs, input int rp,
                        input bit av, input int as_, input bit dv, input int ds);
        req_valid = rv; req_seq = SEQ_W'(rs); req_port = PORT_W'(rp);
        ack_valid = av; ack_seq = SEQ_W'(as_);
        issued_valid = dv; issued_seq = SEQ_W'(ds);
        @(negedge clk);
        req_valid = 1'b0; ack_valid = 1'b0; issued_valid = 1'b0;
    endtask

    task automatic req(input int s, input int p);  step(1, s, p, 0, 0, 0, 0); endtask
    task automatic ack(input int s);               step(0, 0, 0, 1, s, 0, 0); endtask
    task automatic done(input int s);              step(0, 0, 0, 0, 0, 1, s); endtask
    task automatic idle();                         step(0, 0, 0, 0, 0, 0, 0); endtask

    task automatic probe_ready(input string tag, input int s, input bit exp);
        req_valid = 1'b1; req_seq = SEQ_W'(s);
        #1;
        chk(tag, req_ready, exp);
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 cmp_valid", cmp_valid, 0);
        chk("R11 ack_err", ack_err, 0);
        probe_ready("R11 req_ready", 1, 1);
    endtask

    task automatic t_basic();
        req(5, 2);
        chk_cmp("R1 first", 0, 0, 0);
        req(5, 7);
        req(5, 7);
        done(5);
        chk_cmp("R3 issued but pending", 0, 0, 0);
        ack(5);
        chk("R2 ack err", ack_err, 0);
        ack(5);
        chk_cmp("R2 one left", 0, 0, 0);
        ack(5);
        chk_cmp("R3 R6 complete", 1, 5, 2);
        idle();
        chk_cmp("R4 single pulse", 0, 0, 0);
        ack(5);
        chk("R4 ack after free", ack_err, 1);
        idle();
        chk("R5 err pulse ends", ack_err, 0);
    endtask

    task automatic t_acks_first();
        req(9, 4);
        ack(9);
        chk_cmp("R3 count zero not issued", 0, 0, 0);
        chk("R2 valid ack", ack_err, 0);
        done(9);
        chk_cmp("R3 issued last", 1, 9, 4);
    endtask

    task automatic t_same_cycle();
        req(3, 1);
        req(3, 1);
        step(1, 3, 1, 1, 3, 0, 0);
        chk("R7 no err", ack_err, 0);
        done(3);
        ack(3);
        chk_cmp("R7 count held", 0, 0, 0);
        ack(3);
        chk_cmp("R7 final", 1, 3, 1);
    endtask

    task automatic t_full();
        for (int k = 0; k < 4; k++) req(10 + k, k);
        probe_ready("R8 full new seq", 14, 0);
        probe_ready("R8 full tracked seq", 10, 1);
        for (int k = 0; k < 14; k++) req(10, 0);
        probe_ready("R8 saturated", 10, 0);
        done(10);
        for (int k = 0; k < 14; k++) ack(10);
        chk_cmp("R8 still one left", 0, 0, 0);
        ack(10);
        chk_cmp("R8 saturated done", 1, 10, 0);
        probe_ready("R8 slot freed", 14, 1);
        for (int k = 1; k < 4; k++) begin
            done(10 + k);
            ack(10 + k);
            chk_cmp("R1 drain", 1, 10 + k, k);
        end
    endtask

    task automatic t_underflow();
        req(20, 6);
        ack(20);
        chk("R5 legal ack", ack_err, 0);
        ack(20);
        chk("R5 zero count ack", ack_err, 1);
        done(20);
        chk_cmp("R5 state untouched", 1, 20, 6);
        ack(77);
        chk("R5 unknown seq", ack_err, 1);
    endtask

    task automatic t_priority();
        req(30, 8);
        req(31, 9);
        ack(30);
        done(31);
        step(0, 0, 0, 1, 31, 1, 30);
        chk_cmp("R9 lowest first", 1, 30, 8);
        idle();
        chk_cmp("R9 second next", 1, 31, 9);
        idle();
        chk_cmp("R9 no third", 0, 0, 0);
    endtask

    task automatic t_stray_issued();
        done(40);
        req(40, 3);
        ack(40);
        chk_cmp("R10 stray flag ignored", 0, 0, 0);
        done(40);
        chk_cmp("R10 real flag", 1, 40, 3);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_acks_first();
        t_same_cycle();
        t_full();
        t_underflow();
        t_priority();
        t_stray_issued();
        finish_run();
    end

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end
endmodule